// File: doc/BRIEF.md
# Push-Button Synthesizer Frequency Stepper

This block keeps two 24-bit frequency words, one for receive and one for transmit, that feed a direct digital synthesizer. Both words are stepped from three front-panel controls: a raise button, a lower button and a fine/coarse toggle. All three controls are asynchronous and pass through synchronizing flip-flops before any logic uses them. Both words always move together by the same amount.

A hold-off timer paces the steps. While a button is held, the words step once per `HOLDOFF` clock cycles, which is about a quarter second with a 1 MHz clock and the default setting. Each step raises a one-cycle load request so that a downstream loader can copy the new words into the synthesizer. A two-cycle end-of-cycle marker follows as a test point.

Top module: `dds_tune_stepper`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rx_word_o` equals `RX_INIT`, `tx_word_o` equals `TX_INIT`, and `load_req_o` and `cycle_done_o` are low.
- R2: With `fine_i` high, a step changes each word by `STEP_FINE` (default 10).
- R3: With `fine_i` low, a step changes each word by `STEP_COARSE` (default 1000).
- R4: `up_i` adds the step and `down_i` subtracts it. Both words change by the same amount in the same cycle, and all arithmetic wraps modulo 2^24.
- R5: When neither button is pressed, both words hold their value and no load request is raised.
- R6: When both buttons are pressed at the same time, no step is taken and both words hold their value.
- R7: When the timer is ready (after reset, or after a step once `HOLDOFF` cycles have elapsed), a press is seen on the third rising edge after the input changes. A held button then steps exactly every `HOLDOFF` cycles.
- R8: `load_req_o` is high for one cycle, in the same cycle in which the words first show their new values.
- R9: `cycle_done_o` is high for exactly the two cycles that follow each load request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_i | input | 1 | Raise-frequency button, asynchronous |
| down_i | input | 1 | Lower-frequency button, asynchronous |
| fine_i | input | 1 | Step size select, asynchronous: 1 = fine, 0 = coarse |
| rx_word_o | output | W | Receive frequency word |
| tx_word_o | output | W | Transmit frequency word |
| load_req_o | output | 1 | One-cycle request to load the new words |
| cycle_done_o | output | 1 | Two-cycle end-of-update marker |

## Verification
The bench holds the raise button with coarse steps across the top of the 24-bit range, and holds the lower button with both step sizes, driving the receive word below zero. This separates the two step sizes and the two directions, and it shows that wrapping is modulo 2^24. Long idle stretches and a stretch with both buttons pressed show that the words stay still, and that the held-button case differs from the no-button case. The gap between the press and the first step, and between the steps of a held button, is measured to confirm the synchronizer latency and the hold-off spacing.

// File: rtl/dds_tune_stepper.sv
module dds_tune_stepper #(
  parameter int          W           = 24,
  parameter logic [23:0] RX_INIT     = 24'd7040000,
  parameter logic [23:0] TX_INIT     = 24'd7041500,
  parameter int          STEP_FINE   = 10,
  parameter int          STEP_COARSE = 1000,
  parameter int          HOLDOFF     = 250000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_i,
  input  logic         down_i,
  input  logic         fine_i,
  output logic [W-1:0] rx_word_o,
  output logic [W-1:0] tx_word_o,
  output logic         load_req_o,
  output logic         cycle_done_o
);
  localparam int          TW     = $clog2(HOLDOFF);
  localparam logic [TW-1:0] RELOAD = TW'(HOLDOFF - 1);
  localparam logic [W-1:0]  D_FINE = W'(STEP_FINE);
  localparam logic [W-1:0]  D_CRS  = W'(STEP_COARSE);

  logic [SYNC_STAGES-1:0] up_s, dn_s, fn_s;
  logic [TW-1:0]          wait_q;
  logic [1:0]             done_q;
  logic                   up, dn, fine, step;
  logic [W-1:0]           delta;

  always_ff @(posedge clk) begin
    up_s <= {up_s[SYNC_STAGES-2:0], up_i};
    dn_s <= {dn_s[SYNC_STAGES-2:0], down_i};
    fn_s <= {fn_s[SYNC_STAGES-2:0], fine_i};
  end

  assign up    = up_s[SYNC_STAGES-1];
  assign dn    = dn_s[SYNC_STAGES-1];
  assign fine  = fn_s[SYNC_STAGES-1];
  assign step  = (wait_q == '0) && (up ^ dn);
  assign delta = fine ? D_FINE : D_CRS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_word_o  <= W'(RX_INIT);
      tx_word_o  <= W'(TX_INIT);
      wait_q     <= '0;
      load_req_o <= 1'b0;
      done_q     <= '0;
    end else begin
      load_req_o <= step;
      done_q     <= {done_q[0], load_req_o};
      if (step) begin
        wait_q    <= RELOAD;
        rx_word_o <= up ? rx_word_o + delta : rx_word_o - delta;
        tx_word_o <= up ? tx_word_o + delta : tx_word_o - delta;
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign cycle_done_o = |done_q;
endmodule

module dds_tune_stepper_chk #(
  parameter int W       = 24,
  parameter int HOLDOFF = 250000
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] rx_word_o,
  input logic [W-1:0] tx_word_o,
  input logic         load_req_o,
  input logic         cycle_done_o
);
  localparam int GW = $clog2(HOLDOFF + 1);
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (load_req_o) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q != GW'(HOLDOFF)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req_o |-> ($stable(rx_word_o) && $stable(tx_word_o))); // R5
  AST_WORDS_MOVE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    load_req_o |-> (W'(rx_word_o - $past(rx_word_o)) == W'(tx_word_o - $past(tx_word_o)))); // R4
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_req_o |=> !load_req_o); // R8
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_req_o) |-> cycle_done_o); // R9
  AST_DONE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cycle_done_o) |=> cycle_done_o); // R9
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done_o && $past(cycle_done_o)) |=> !cycle_done_o); // R9
  AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req_o && seen_q) |-> (gap_q == GW'(HOLDOFF))); // R7
endmodule

bind dds_tune_stepper dds_tune_stepper_chk #(.W(W), .HOLDOFF(HOLDOFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_word_o(rx_word_o), .tx_word_o(tx_word_o),
  .load_req_o(load_req_o), .cycle_done_o(cycle_done_o)
);

// File: tb/test_dds_tune_stepper.sv
module test_dds_tune_stepper;
  localparam int CLK_PERIOD = 10;
  localparam int H   = 16;
  localparam logic [23:0] RX0 = 24'd5;
  localparam logic [23:0] TX0 = 24'hFFFF00;
  localparam int SF = 10, SC = 1000;

  typedef struct { logic [23:0] rx; logic [23:0] tx; string rq; } exp_t;

  logic clk = 0, rst_n = 0, up = 0, dn = 0, fine = 0;
  logic [23:0] rx, tx;
  logic ld, done;
  int errs = 0, checks = 0, cyc = 0, pulses = 0, last_cyc = 0;
  bit finished = 0;
  exp_t q[$];
  logic [23:0] mrx = RX0, mtx = TX0;

  dds_tune_stepper #(.RX_INIT(RX0), .TX_INIT(TX0), .STEP_FINE(SF),
    .STEP_COARSE(SC), .HOLDOFF(H)) i_dds_tune_stepper (
    .clk(clk), .rst_n(rst_n), .up_i(up), .down_i(dn), .fine_i(fine),
    .rx_word_o(rx), .tx_word_o(tx), .load_req_o(ld), .cycle_done_o(done));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // monitor: pop and compare on each load request, then follow the marker
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ld) begin
        exp_t e;
        pulses++;
        last_cyc = cyc;
        if (q.size() == 0) begin
          chk(0, "R5/R6 unexpected step", rx, -1);
        end else begin
          e = q.pop_front();
          chk(rx == e.rx, {e.rq, " rx"}, rx, e.rx);
          chk(tx == e.tx, {e.rq, " tx"}, tx, e.tx);
        end
        chk(done == 0, "R9 marker before", done, 0);
        @(negedge clk);
        chk(ld == 0, "R8 load one cycle", ld, 0);
        chk(done == 1, "R9 marker cycle 1", done, 1);
        @(negedge clk);
        chk(done == 1, "R9 marker cycle 2", done, 1);
        @(negedge clk);
        chk(done == 0, "R9 marker end", done, 0);
      end
    end
  end

  task automatic burst(input bit u, input bit d, input bit f, input int n, input string rq);
    int start, target, prev;
    logic [23:0] dl;
    dl = f ? 24'(SF) : 24'(SC);
    for (int i = 0; i < n; i++) begin
      mrx = u ? mrx + dl : mrx - dl;
      mtx = u ? mtx + dl : mtx - dl;
      q.push_back('{mrx, mtx, rq});
    end
    target = pulses + n;
    @(negedge clk);
    up = u; dn = d; fine = f;
    start = cyc;
    wait (pulses == target - n + 1);
    chk(last_cyc - start == 3, "R7 first-step latency", last_cyc - start, 3);
    prev = last_cyc;
    for (int i = 1; i < n; i++) begin
      wait (pulses == target - n + 1 + i);
      chk(last_cyc - prev == H, "R7 repeat spacing", last_cyc - prev, H);
      prev = last_cyc;
    end
    up = 0; dn = 0;
    repeat (H + 6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rx == RX0, "R1 rx reset", rx, RX0);
    chk(tx == TX0, "R1 tx reset", tx, TX0);
    rst_n = 1;
    @(negedge clk);
    chk(rx == RX0 && tx == TX0, "R1 after release", rx, RX0);
    chk(ld == 0 && done == 0, "R1 outputs low", {ld, done}, 0);

    repeat (2 * H) @(negedge clk);
    chk(rx == RX0 && tx == TX0, "R5 idle hold", rx, RX0);
    chk(pulses == 0, "R5 no request idle", pulses, 0);

    burst(1, 0, 0, 3, "R3 coarse up, R4 tx wrap");
    burst(0, 1, 1, 2, "R2 fine down");
    burst(0, 1, 0, 4, "R4 rx wraps below zero");

    begin
      int p0;
      p0 = pulses;
      @(negedge clk);
      up = 1; dn = 1; fine = 0;
      repeat (3 * H) @(negedge clk);
      chk(pulses == p0, "R6 both pressed no step", pulses, p0);
      chk(rx == mrx, "R6 rx held", rx, mrx);
      chk(tx == mtx, "R6 tx held", tx, mtx);
      up = 0; dn = 0;
      repeat (H + 6) @(negedge clk);
    end

    burst(1, 0, 1, 1, "R2 fine up");
    repeat (H) @(negedge clk);
    chk(rx == mrx && tx == mtx, "R5 final hold", rx, mrx);
    chk(q.size() == 0, "R4 all steps seen", q.size(), 0);
    finish_run();
  end
endmodule